// File: doc/BRIEF.md
# Odd/Even Byte-Lane Memory Bank Controller

This block sits between a 16-bit processor bus and a memory built from two byte-wide banks. The low bank stores every byte at an even address and is wired to data bits 7:0. The high bank stores every byte at an odd address and is wired to data bits 15:8.

Each request carries a byte address, an active-low high-byte enable and a read/write flag. The address bit 0 and the high-byte enable together select one of three access types or a refresh indication:
- a 16-bit word at an even address,
- a single odd byte,
- a single even byte,
- a refresh.

Address bit 0 only picks lanes and never reaches the banks. Both banks are always indexed by the word address, which is the byte address shifted right by one.

Every accepted request is answered exactly one cycle later. The answer carries the lanes that took part, the read data and a refresh flag. A refresh moves no data and changes no bank.

Top module: `lane_bank_ctrl`

## Requirements
- R1: After reset, while no request was presented on the previous clock edge, `rsp_valid`, `rsp_refresh`, `rsp_lanes` and `rsp_rdata` are all zero.
- R2: A request sampled with `req_valid` high on a clock edge produces `rsp_valid` high for exactly the following cycle. Back-to-back requests produce back-to-back responses.
- R3: The lanes are decoded as follows, with `rsp_lanes` bit 1 being the high bank and bit 0 the low bank:
  - `req_bhe_n`=0 and `req_addr[0]`=0 gives lanes 2'b11 (word).
  - `req_bhe_n`=0 and `req_addr[0]`=1 gives lanes 2'b10 (odd byte).
  - `req_bhe_n`=1 and `req_addr[0]`=0 gives lanes 2'b01 (even byte).
  - `req_bhe_n`=1 and `req_addr[0]`=1 gives lanes 2'b00 (refresh).
- R4: Both banks are indexed by `req_addr[ADDR_W-1:1]`. Byte addresses 2k and 2k+1 reach the same word, so their bytes read back together as one word at 2k.
- R5: On a write, the low bank takes `req_wdata[7:0]` and the high bank takes `req_wdata[15:8]`. Only enabled banks update; a disabled bank keeps its contents.
- R6: On a read, the low bank appears on `rsp_rdata[7:0]` and the high bank on `rsp_rdata[15:8]`. The lane of a disabled bank reads as zero.
- R7: A refresh gives `rsp_refresh`=1, lanes 2'b00 and `rsp_rdata`=0 in one response cycle. It leaves both banks unchanged even with `req_write`=1.
- R8: The response to a write has `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bit 0 selects lanes only |
| req_bhe_n | input | 1 | Active-low high-byte enable |
| req_wdata | input | 16 | Write data, odd byte on bits 15:8 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_refresh | output | 1 | Response belongs to a refresh cycle |
| rsp_lanes | output | 2 | Lanes used: bit 1 high bank, bit 0 low bank |
| rsp_rdata | output | 16 | Read data, zero on disabled lanes and on writes |

## Verification
Some internal faults show up at the ports on the next response:
- A wrong lane decode changes `rsp_lanes`.
- A wrong lane decode also zeroes or exposes a byte in `rsp_rdata`.

Other faults stay hidden until a later read of the same word:
- A bank written while disabled.
- A bank indexed with A0 still attached.

These faults surface on the first read that covers the damaged byte. For that reason the stimulus always reads back a word after a partial or refresh write, and compares both lanes against a byte-level model.

// File: rtl/lane_bank_pkg.sv
package lane_bank_pkg;

  // Lane code: bit 1 = high (odd) bank, bit 0 = low (even) bank
  typedef enum logic [1:0] {
    ACC_REFRESH = 2'b00,
    ACC_EVEN    = 2'b01,
    ACC_ODD     = 2'b10,
    ACC_WORD    = 2'b11
  } lane_sel_e;

  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  // Lane selection from active-low high enable and address bit 0
  function automatic lane_sel_e pick_lanes(input logic bhe_n, input logic a0);
    logic hi, lo;
    hi = ~bhe_n;
    lo = ~a0;
    return lane_sel_e'({hi, lo});
  endfunction

  // Byte lane index of a bank within the 16-bit bus
  function automatic int lane_lsb(input int lane);
    return lane * BYTE_W;
  endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_bank_pkg::*;
(
  input  logic             valid,
  input  logic             write,
  input  logic             bhe_n,
  input  logic             a0,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] lane_we,
  output logic             refresh
);

  lane_sel_e sel;

  always_comb begin
    sel     = pick_lanes(bhe_n, a0);
    lane_en = valid ? sel : '0;
    lane_we = write ? lane_en : '0;
    refresh = valid && (sel == ACC_REFRESH);
  end

endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
  parameter int WORD_AW = 9,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic [WORD_AW-1:0] addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata
);

  localparam int DEPTH = 1 << WORD_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  // Registered read port: zero unless an enabled read took place
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata <= '0;
    else if (en && !we)   rdata <= mem[addr];
    else                  rdata <= '0;
  end

endmodule

// File: rtl/lane_bank_ctrl.sv
module lane_bank_ctrl
  import lane_bank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bhe_n,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_refresh,
  output logic [1:0]        rsp_lanes,
  output logic [15:0]       rsp_rdata
);

  localparam int WORD_AW = ADDR_W - 1;

  // Named internal events
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  lane_we;
  logic              is_refresh;
  logic [WORD_AW-1:0] bank_addr;
  logic [DATA_W-1:0] bank_rdata;

  assign bank_addr = req_addr[ADDR_W-1:1];

  lane_decode u_dec (
    .valid   (req_valid),
    .write   (req_write),
    .bhe_n   (req_bhe_n),
    .a0      (req_addr[0]),
    .lane_en (lane_en),
    .lane_we (lane_we),
    .refresh (is_refresh)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    byte_bank #(
      .WORD_AW (WORD_AW),
      .BYTE_W  (BYTE_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (lane_en[g]),
      .we    (lane_we[g]),
      .addr  (bank_addr),
      .wdata (req_wdata[lane_lsb(g) +: BYTE_W]),
      .rdata (bank_rdata[lane_lsb(g) +: BYTE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_refresh <= 1'b0;
      rsp_lanes   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_refresh <= is_refresh;
      rsp_lanes   <= lane_en;
    end
  end

  assign rsp_rdata = bank_rdata;

endmodule

// File: rtl/lane_bank_chk.sv
module lane_bank_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_bhe_n,
  input logic              rsp_valid,
  input logic              rsp_refresh,
  input logic [1:0]        rsp_lanes,
  input logic [15:0]       rsp_rdata,
  input logic [1:0]        lane_we,
  input logic              is_refresh
);

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == 16'h0 && !rsp_refresh && rsp_lanes == 2'b00));

  p_high_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_bhe_n) |=> rsp_lanes[1]);

  p_low_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[0]) |=> rsp_lanes[0]);

  p_dead_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_lanes[0] || rsp_rdata[7:0] == 8'h0) &&
                   (rsp_lanes[1] || rsp_rdata[15:8] == 8'h0)));

  p_refresh_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_refresh |-> (rsp_lanes == 2'b00 && rsp_rdata == 16'h0));

  p_refresh_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_refresh |-> (lane_we == 2'b00));

  p_write_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 16'h0));

endmodule

bind lane_bank_ctrl lane_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_bhe_n   (req_bhe_n),
  .rsp_valid   (rsp_valid),
  .rsp_refresh (rsp_refresh),
  .rsp_lanes   (rsp_lanes),
  .rsp_rdata   (rsp_rdata),
  .lane_we     (lane_we),
  .is_refresh  (is_refresh)
);

// File: tb/sim_lane_bank_ctrl.sv
module sim_lane_bank_ctrl;

  localparam int ADDR_W = 10;
  localparam int WORDS  = 1 << (ADDR_W - 1);

  typedef struct {
    logic        refresh;
    logic [1:0]  lanes;
    logic [15:0] rdata;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_bhe_n = 1'b1;
  logic [15:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_refresh;
  logic [1:0]        rsp_lanes;
  logic [15:0]       rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  exp_t sb[$];
  logic [7:0] even_m [WORDS];
  logic [7:0] odd_m  [WORDS];

  always #2 clk = ~clk;

  lane_bank_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bhe_n(req_bhe_n), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_refresh(rsp_refresh), .rsp_lanes(rsp_lanes),
    .rsp_rdata(rsp_rdata)
  );

  // Driver: present one request for one cycle and push the expected answer
  task automatic issue(input logic wr, input int addr, input logic bhe_n,
                       input logic [15:0] wd, input string tag);
    exp_t e;
    int w;
    logic hi, lo;
    @(negedge clk);
    w  = addr / 2;
    hi = (bhe_n == 1'b0);
    lo = (addr % 2 == 0);
    e.lanes   = {hi, lo};
    e.refresh = !hi && !lo;
    e.tag     = tag;
    e.rdata   = 16'h0;
    if (wr) begin
      if (lo) even_m[w] = wd[7:0];
      if (hi) odd_m[w]  = wd[15:8];
    end else begin
      if (hi) e.rdata[15:8] = odd_m[w];
      if (lo) e.rdata[7:0]  = even_m[w];
    end
    sb.push_back(e);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr[ADDR_W-1:0];
    req_bhe_n = bhe_n;
    req_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      req_wdata = 16'hDEAD;
    end
  endtask

  // Monitor: compare every cycle shortly after the rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      checks++;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (!rsp_valid || rsp_refresh !== e.refresh || rsp_lanes !== e.lanes ||
            rsp_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s: valid=%b refresh=%b lanes=%b rdata=%h exp valid=1 refresh=%b lanes=%b rdata=%h",
                   e.tag, rsp_valid, rsp_refresh, rsp_lanes, rsp_rdata,
                   e.refresh, e.lanes, e.rdata);
        end
      end else if (rsp_valid !== 1'b0 || rsp_refresh !== 1'b0 ||
                   rsp_lanes !== 2'b00 || rsp_rdata !== 16'h0) begin
        errors++;
        $display("FAIL R1/R2 idle: valid=%b refresh=%b lanes=%b rdata=%h exp all zero",
                 rsp_valid, rsp_refresh, rsp_lanes, rsp_rdata);
      end
    end
  end

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);                                              // R1 reset state

    issue(1'b1, 16'h010, 1'b0, 16'hBEEF, "R5 word write");
    issue(1'b0, 16'h010, 1'b0, 16'h0,    "R6 word read");  // R2 back to back
    issue(1'b0, 16'h011, 1'b0, 16'h0,    "R3 odd byte read");
    issue(1'b0, 16'h010, 1'b1, 16'h0,    "R3 even byte read");
    idle(1);

    issue(1'b1, 16'h021, 1'b0, 16'hAB00, "R4 odd byte write");
    issue(1'b1, 16'h020, 1'b1, 16'h00CD, "R4 even byte write");
    issue(1'b0, 16'h020, 1'b0, 16'h0,    "R4 word at shared index");
    idle(1);

    issue(1'b1, 16'h030, 1'b0, 16'h1234, "R5 word write");
    issue(1'b1, 16'h031, 1'b0, 16'h77FF, "R5 high only write");
    issue(1'b0, 16'h030, 1'b0, 16'h0,    "R5 low kept");
    issue(1'b1, 16'h030, 1'b1, 16'h5566, "R5 low only write");
    issue(1'b0, 16'h030, 1'b0, 16'h0,    "R5 high kept");

    issue(1'b1, 16'h031, 1'b1, 16'hFFFF, "R7 refresh write");
    issue(1'b0, 16'h031, 1'b1, 16'h0,    "R7 refresh read");
    issue(1'b0, 16'h030, 1'b0, 16'h0,    "R7 banks unchanged");
    idle(2);

    issue(1'b1, 16'h3FE, 1'b0, 16'hC0DE, "R8 top word write");
    issue(1'b0, 16'h3FF, 1'b0, 16'h0,    "R6 top odd read");
    issue(1'b0, 16'h3FE, 1'b1, 16'h0,    "R6 top even read");

    for (int k = 0; k < 16; k++) begin
      issue(1'b1, 16'h100 + 2 * k, 1'b0, 16'(k * 16'h1111 + 16'h0102), "R5 sweep write");
    end
    for (int k = 0; k < 16; k++) begin
      issue(1'b0, 16'h100 + 2 * k + (k % 2), (k % 3 == 0), 16'h0, "R3 sweep read");
    end
    idle(3);

    done = 1'b1;
    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule